// File: doc/BRIEF.md
# Four-Phase Handshake Bus Master

This block is the initiating side of an unclocked request/acknowledge bus that connects to a single responder. A user-side command gives an address, a direction and write data. The master then drives the address, the direction line and (on writes) the data onto the bus. It holds them for a programmable settle time so the responder can decode the target, and only then raises request.

The responder answers by raising acknowledge. On a write this means the data has been taken. On a read it means valid data is on the bus. The master drops request on seeing acknowledge high and captures read data at that same edge. It treats the transfer as finished once acknowledge has gone low again, and it signals this with a one-cycle done pulse.

Acknowledge is not related to the master clock. It therefore passes through a two-flop synchronizer before the sequencing logic uses it. The data bus is modelled as separate in and out buses plus an output enable.

Top module: `hsk_master`

## Requirements
- R1: After reset, bus_req, bus_doe, done and rdata are 0, bus_addr is 0 and cmd_ready is 1.
- R2: On the clock edge that accepts a command, bus_addr, bus_rnw (1 = read) and bus_dout take the command values. They then stay unchanged until the transfer completes.
- R3: bus_req rises exactly settle_cycles+1 clock edges after the accepting edge. The value of settle_cycles is taken at acceptance, so 0 raises request on the next edge.
- R4: bus_req stays high for as long as the synchronized acknowledge is low, and falls only after it has seen acknowledge high.
- R5: done is not raised while acknowledge is still high. It is raised only after bus_req is low and the synchronized acknowledge has been seen low.
- R6: On a read, rdata takes bus_din at the edge where bus_req falls, and holds that value afterwards even when bus_din changes. A write leaves rdata unchanged.
- R7: bus_doe is 1 only on writes, from the accepting edge until the completion edge. It is always 0 on reads.
- R8: done is high for exactly one cycle per transfer. cmd_ready returns to 1 in that same cycle.
- R9: A command is accepted only while cmd_ready is 1. A cmd_valid presented during a transfer changes nothing on the bus and starts no later transfer.
- R10: bus_ack passes through two synchronizer flops. A rise on bus_ack between two edges drops bus_req at the third following edge. A fall on bus_ack between two edges raises done at the third following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Write data |
| settle_cycles | input | CW | Extra decode-settle cycles before request |
| cmd_ready | output | 1 | Idle, command will be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last captured read data |
| bus_addr | output | AW | Bus address |
| bus_rnw | output | 1 | Bus direction, 1 = read |
| bus_dout | output | DW | Data driven onto bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DW | Data from the responder |
| bus_req | output | 1 | Request line |
| bus_ack | input | 1 | Acknowledge from the responder, asynchronous |

## Verification
The bench sweeps settle counts from zero upward across both directions and several responder delays. It counts the exact edge at which request rises, so an off-by-one in the settle counter, or a zero count that waits a full extra cycle, shows up directly. It measures the edges from each acknowledge change to request falling and to done, which catches a synchronizer with a missing or extra stage. After each read it switches the responder data to junk, so a master that captured after acknowledge fell would report the junk. It also pokes conflicting commands during transfers, so a master that accepted commands outside idle would move the address or start a stray transfer.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_REQ    = 2'd2,
        ST_REL    = 2'd3
    } hsk_state_t;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/hsk_settle.sv
module hsk_settle #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3: the settle count steps down by one per cycle when not reloaded
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/hsk_master.sv
module hsk_master
    import hsk_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [CW-1:0] settle_cycles,
    output logic          cmd_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rnw,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    output logic          bus_req,
    input  logic          bus_ack
);
    typedef struct packed {
        hsk_state_t    st;
        logic [AW-1:0] addr;
        logic          rnw;
        logic [DW-1:0] wd;
        logic          doe;
        logic          req;
        logic          done;
        logic [DW-1:0] rd;
    } regs_t;

    regs_t r_d, r_q;
    logic  ack_s;
    logic  settle_zero;
    logic  settle_load;

    hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_ack),
        .dout (ack_s)
    );

    hsk_settle #(.CW(CW)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .load_val(settle_cycles),
        .zero    (settle_zero)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        settle_load = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr    = cmd_addr;
                    r_d.rnw     = !cmd_write;
                    r_d.wd      = cmd_wdata;
                    r_d.doe     = cmd_write;
                    settle_load = 1'b1;
                    r_d.st      = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_zero) begin
                    r_d.req = 1'b1;
                    r_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (ack_s) begin
                    r_d.req = 1'b0;
                    if (r_q.rnw) r_d.rd = bus_din;
                    r_d.st  = ST_REL;
                end
            end
            ST_REL: begin
                if (!ack_s) begin
                    r_d.doe  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.addr <= '0;
            r_q.rnw  <= 1'b1;
            r_q.wd   <= '0;
            r_q.doe  <= 1'b0;
            r_q.req  <= 1'b0;
            r_q.done <= 1'b0;
            r_q.rd   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == ST_IDLE);
    assign done      = r_q.done;
    assign rdata     = r_q.rd;
    assign bus_addr  = r_q.addr;
    assign bus_rnw   = r_q.rnw;
    assign bus_dout  = r_q.wd;
    assign bus_doe   = r_q.doe;
    assign bus_req   = r_q.req;

    // R2: bus fields stay put throughout a transfer
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(!cmd_ready)) |->
            ($stable(bus_addr) && $stable(bus_rnw) && $stable(bus_dout)));

    // R3: request rises only once the settle counter has expired
    p_req_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(settle_zero) && $past(r_q.st == ST_SETTLE)));

    // R4: request drops only after synchronized acknowledge was high
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(ack_s));

    // R5: completion only after acknowledge seen low with request released
    p_done_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && $past(!ack_s)));

    // R7: data output enable only on writes, only while busy
    p_doe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_rnw && !cmd_ready));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: idle with no command stays idle
    p_idle_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> (cmd_ready && !bus_req));
endmodule

// File: tb/hsk_master_bench.sv
module hsk_master_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic       cmd_write;
    logic [7:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic [7:0] settle_cycles;
    logic       cmd_ready;
    logic       done;
    logic [7:0] rdata;
    logic [7:0] bus_addr;
    logic       bus_rnw;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic [7:0] bus_din;
    logic       bus_req;
    logic       bus_ack;

    int total = 0;
    int bad   = 0;
    logic [7:0] last_rd = 8'h00;

    always #10 clk = ~clk;

    hsk_master #(.AW(8), .DW(8), .CW(8), .SYNC_STAGES(2)) u_hsk_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .settle_cycles(settle_cycles),
        .cmd_ready(cmd_ready), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_rnw(bus_rnw), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_req(bus_req), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                        input logic [7:0] sd, input logic [7:0] rdv,
                        input int dly, input bit poke);
        int n;
        logic [7:0] exp_rd;
        exp_rd = wr ? last_rd : rdv;
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R9 ready before command", int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a;
        cmd_wdata = wd; settle_cycles = sd;
        @(negedge clk);
        if (poke) begin
            cmd_addr = ~a; cmd_write = !wr; cmd_wdata = ~wd; settle_cycles = 8'd0;
        end else begin
            cmd_valid = 1'b0;
        end
        chk(bus_addr === a, "R2 address driven", int'(bus_addr), int'(a));
        chk(bus_rnw === !wr, "R2 direction driven", int'(bus_rnw), int'(!wr));
        if (wr) chk(bus_dout === wd, "R2 write data driven", int'(bus_dout), int'(wd));
        chk(bus_doe === wr, "R7 output enable on accept", int'(bus_doe), int'(wr));
        chk(cmd_ready === 1'b0, "R9 busy after accept", int'(cmd_ready), 0);
        n = 0;
        while (bus_req !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
            if (poke) chk(bus_addr === a, "R9 poke leaves address", int'(bus_addr), int'(a));
        end
        cmd_valid = 1'b0;
        chk(n == int'(sd) + 1, "R3 settle edges", n, int'(sd) + 1);
        repeat (dly) @(negedge clk);
        chk(bus_req === 1'b1, "R4 request held without ack", int'(bus_req), 1);
        bus_din = rdv; bus_ack = 1'b1;
        n = 0;
        while (bus_req !== 1'b0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R10 ack rise to request fall", n, 3);
        chk(rdata === exp_rd, "R6 read capture", int'(rdata), int'(exp_rd));
        chk(done === 1'b0, "R5 no done while ack high", int'(done), 0);
        last_rd = exp_rd;
        repeat (dly) @(negedge clk);
        chk(done === 1'b0 && cmd_ready === 1'b0, "R5 waiting for ack low", int'(done), 0);
        chk(bus_addr === a, "R2 address held until ack low", int'(bus_addr), int'(a));
        bus_ack = 1'b0; bus_din = ~rdv;
        n = 0;
        while (done !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
            if (done !== 1'b1) chk(bus_doe === wr, "R7 enable held until done", int'(bus_doe), int'(wr));
        end
        chk(n == 3, "R10 ack fall to done", n, 3);
        chk(cmd_ready === 1'b1, "R8 ready with done", int'(cmd_ready), 1);
        chk(bus_doe === 1'b0, "R7 enable off at completion", int'(bus_doe), 0);
        chk(rdata === exp_rd, "R6 held after data change", int'(rdata), int'(exp_rd));
        @(negedge clk);
        chk(done === 1'b0, "R8 done single cycle", int'(done), 0);
        chk(bus_req === 1'b0 && cmd_ready === 1'b1, "R9 no stray transfer", int'(bus_req), 0);
        chk(bus_addr === a, "R9 address unchanged after poke", int'(bus_addr), int'(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0;
        cmd_wdata = '0; settle_cycles = '0; bus_din = '0; bus_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_req === 1'b0, "R1 reset request", int'(bus_req), 0);
        chk(bus_doe === 1'b0, "R1 reset enable", int'(bus_doe), 0);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        chk(cmd_ready === 1'b1, "R1 reset ready", int'(cmd_ready), 1);
        chk(rdata === 8'h00, "R1 reset rdata", int'(rdata), 0);
        chk(bus_addr === 8'h00, "R1 reset address", int'(bus_addr), 0);
        rst_n = 1'b1;
        for (int sd = 0; sd < 5; sd++) begin
            for (int dly = 0; dly < 3; dly++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    logic [7:0] a;
                    a = 8'(sd * 16 + dly * 4 + rw + 1);
                    xfer(rw[0], a, a ^ 8'hA5, 8'(sd), a ^ 8'h3C, dly, ((sd + dly) % 2) == 1);
                end
            end
        end
        xfer(1'b0, 8'hFF, 8'h00, 8'd9, 8'h81, 1, 1'b1);
        xfer(1'b1, 8'h00, 8'hFF, 8'd0, 8'h7E, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule